// File: doc/BRIEF.md
# Serial Configuration Register Port

This block receives 16-bit control words over a three-line serial port (a latch line, a shift clock and a data line) and writes them into four configuration registers. Two address bits in each word pick the target register. The register contents are decoded into the settings an audio interpolation path needs:

- per-channel attenuation
- mute
- de-emphasis enable and rate
- input format and output word length
- left/right clock polarity
- filter roll-off
- clock-out divider

The serial lines are asynchronous to the system clock. They are resynchronised and edge-detected inside the block, so the shift clock and the latch line must each stay at one level for a few system clocks.

A mode input selects where the configuration comes from. When it is high, the outputs come from the registers. When it is low, they come straight from a set of dedicated pins; in that mode attenuation is held at 0 dB and the mute pin is active low. Attenuation uses a load-gated scheme: a stored level reaches the output only when the word that carries it also sets its load bit. A common-data bit makes the left level govern both channels.

Top module: `serial_cfg_top`

## Requirements
- R1: A control word is shifted in MSB first (bit 15 first), one bit per rising edge of `ctl_clk`. It is committed on the rising edge of `ctl_latch`. Word bits 10:9 select the register (00, 01, 10 or 11 for registers 0 to 3), and bits 15:11 are ignored.
- R2: A latch rising edge preceded by any number of shift-clock edges other than 16 (counted since the previous latch rising edge or reset) discards the word and changes no output.
- R3: Register 0 carries the left level in bits 7:0 and the left load bit in bit 8. Register 1 carries the right level in bits 7:0 and the right load bit in bit 8. A write with load = 1 makes the channel's effective level equal to the written code, where FFh means 0 dB, each code step below FFh adds 0.5 dB, and 00h means full mute.
- R4: A register 0 or register 1 write with load = 0 leaves that channel's effective level unchanged.
- R5: Register 3 bit 1 is the common-data bit. When it is 1, `att_right` equals the effective left level. When it is 0, `att_right` is the effective right level.
- R6: Register 2 fields are:
  - output length in bits 5:4 (00 = 16, 01 = 18, 10 = 20, 11 = 24 bits)
  - input format in bits 3:2
  - de-emphasis enable in bit 1
  - mute in bit 0, where 0 means muted (`mute_on` = 1) and 1 means not muted.
- R7: Register 3 fields are:
  - de-emphasis rate in bits 6:5 (00 = 44.1 kHz, 10 = 48 kHz, 11 = 32 kHz, 01 reserved)
  - clock-out divide-by-two in bit 4
  - slow roll-off in bit 2
  - left/right polarity in bit 0 (0 = left while word clock is high).
- R8: After reset, the outputs are:
  - both attenuations FFh
  - mute off and de-emphasis off
  - rate 00, input format 00 and output length 00
  - polarity 0, sharp roll-off (0) and clock-out undivided (0).
- R9: With `sw_mode` = 0, every configuration output follows its pin, `mute_on` = NOT `pin_mute_n`, and both attenuations read FFh. Serial writes are still stored and take effect when `sw_mode` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_mode | input | 1 | 1 = register-driven configuration, 0 = pin-driven |
| ctl_latch | input | 1 | Serial word latch line |
| ctl_clk | input | 1 | Serial shift clock |
| ctl_data | input | 1 | Serial data line |
| pin_in_fmt | input | 2 | Pin-mode input format |
| pin_out_len | input | 2 | Pin-mode output word length |
| pin_dem_on | input | 1 | Pin-mode de-emphasis enable |
| pin_dem_rate | input | 2 | Pin-mode de-emphasis rate |
| pin_mute_n | input | 1 | Pin-mode mute, active low |
| pin_roll_slow | input | 1 | Pin-mode slow roll-off |
| pin_ck_div2 | input | 1 | Pin-mode clock-out divide-by-two |
| pin_lr_pol | input | 1 | Pin-mode left/right polarity |
| att_left | output | 8 | Effective left attenuation code |
| att_right | output | 8 | Effective right attenuation code |
| mute_on | output | 1 | Mute active |
| dem_on | output | 1 | De-emphasis enabled |
| dem_rate | output | 2 | De-emphasis rate code |
| in_fmt | output | 2 | Input format code |
| out_len | output | 2 | Output word length code |
| roll_slow | output | 1 | Slow roll-off selected |
| ck_div2 | output | 1 | Clock-out divided by two |
| lr_pol | output | 1 | Left/right polarity |

## Verification
The bench targets the following corner cases:

- **Short and long words.** It sends words of 15 and 17 bits. A design that committed on any latch edge would corrupt register 2 with a shifted word.
- **Load-gated attenuation.** It writes new attenuation codes with the load bit clear. A design that took these codes directly would move the effective level.
- **Common-data toggling.** It toggles the common-data bit while the two channels hold different levels. This exposes a right output that ignores the bit, or one that copies the left value permanently.
- **Reserved bits and mode switching.** Words carry ones in the reserved bits, which catches an address decoded from the wrong bits. The mode pin is switched with writes issued in between, which catches a pin path that leaks register state or a mute pin of the wrong polarity.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

    localparam int WORD_W  = 16;
    localparam int ATT_W   = 8;
    localparam int ADDR_LO = 9;
    localparam int LOAD_B  = 8;

    typedef enum logic [1:0] {
        SEL_ATT_L = 2'd0,
        SEL_ATT_R = 2'd1,
        SEL_FMT   = 2'd2,
        SEL_SYS   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] out_len;
        logic [1:0] in_fmt;
        logic       dem_on;
        logic       mute_off;
    } fmt_cfg_t;

    typedef struct packed {
        logic [1:0] dem_rate;
        logic       ck_div2;
        logic       roll_slow;
        logic       common_att;
        logic       lr_pol;
    } sys_cfg_t;

    localparam fmt_cfg_t FMT_RESET = '{out_len: 2'b00, in_fmt: 2'b00,
                                       dem_on: 1'b0, mute_off: 1'b1};
    localparam sys_cfg_t SYS_RESET = '{dem_rate: 2'b00, ck_div2: 1'b0,
                                       roll_slow: 1'b0, common_att: 1'b0,
                                       lr_pol: 1'b0};

    function automatic reg_sel_e word_sel(input logic [WORD_W-1:0] w);
        return reg_sel_e'(w[ADDR_LO+1:ADDR_LO]);
    endfunction

    function automatic fmt_cfg_t unpack_fmt(input logic [WORD_W-1:0] w);
        fmt_cfg_t f;
        f.out_len  = w[5:4];
        f.in_fmt   = w[3:2];
        f.dem_on   = w[1];
        f.mute_off = w[0];
        return f;
    endfunction

    function automatic sys_cfg_t unpack_sys(input logic [WORD_W-1:0] w);
        sys_cfg_t s;
        s.dem_rate   = w[6:5];
        s.ck_div2    = w[4];
        s.roll_slow  = w[2];
        s.common_att = w[1];
        s.lr_pol     = w[0];
        return s;
    endfunction

endpackage

// File: rtl/serial_cfg_sync.sv
module serial_cfg_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] rise
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[STAGES-1:0], async_in[g]};
        end
        assign level[g] = pipe[STAGES-1];
        assign rise[g]  = pipe[STAGES-1] & ~pipe[STAGES];
    end
endmodule

// File: rtl/serial_cfg_shift.sv
module serial_cfg_shift
    import serial_cfg_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_rise,
    input  logic         bit_val,
    input  logic         latch_rise,
    output logic [W-1:0] word,
    output logic         word_ok
);
    localparam int CNT_W = $clog2(W + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(W);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(W + 1);

    logic [W-1:0]     sr;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            cnt     <= '0;
            word    <= '0;
            word_ok <= 1'b0;
        end else begin
            word_ok <= 1'b0;
            if (latch_rise) begin
                word_ok <= (cnt == FULL);
                word    <= sr;
                cnt     <= '0;
            end else if (bit_rise) begin
                sr <= {sr[W-2:0], bit_val};
                if (cnt != OVER) cnt <= cnt + 1'b1;
            end
        end
    end

    a_r2_wrong_count_dropped: assert property (@(posedge clk) disable iff (rst)
        (latch_rise && cnt != FULL) |=> !word_ok);
    a_r1_commit_single_pulse: assert property (@(posedge clk) disable iff (rst)
        word_ok |=> !word_ok);
endmodule

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs
    import serial_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    input  logic              word_ok,
    output fmt_cfg_t          fmt,
    output sys_cfg_t          sys,
    output logic [ATT_W-1:0]  lvl_left,
    output logic [ATT_W-1:0]  lvl_right
);
    reg_sel_e sel;
    logic     load;
    assign sel  = word_sel(word);
    assign load = word[LOAD_B];

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt       <= FMT_RESET;
            sys       <= SYS_RESET;
            lvl_left  <= '1;
            lvl_right <= '1;
        end else if (word_ok) begin
            unique case (sel)
                SEL_ATT_L: if (load) lvl_left  <= word[ATT_W-1:0];
                SEL_ATT_R: if (load) lvl_right <= word[ATT_W-1:0];
                SEL_FMT:   fmt <= unpack_fmt(word);
                SEL_SYS:   sys <= unpack_sys(word);
                default: ;
            endcase
        end
    end

    a_r4_left_holds_without_load: assert property (@(posedge clk) disable iff (rst)
        !(word_ok && sel == SEL_ATT_L && load) |=> lvl_left == $past(lvl_left));
    a_r3_right_takes_loaded_code: assert property (@(posedge clk) disable iff (rst)
        (word_ok && sel == SEL_ATT_R && load) |=> lvl_right == $past(word[ATT_W-1:0]));
    a_r6_mute_bit_written: assert property (@(posedge clk) disable iff (rst)
        (word_ok && sel == SEL_FMT) |=> fmt.mute_off == $past(word[0]));
endmodule

// File: rtl/serial_cfg_top.sv
module serial_cfg_top
    import serial_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_mode,
    input  logic             ctl_latch,
    input  logic             ctl_clk,
    input  logic             ctl_data,
    input  logic [1:0]       pin_in_fmt,
    input  logic [1:0]       pin_out_len,
    input  logic             pin_dem_on,
    input  logic [1:0]       pin_dem_rate,
    input  logic             pin_mute_n,
    input  logic             pin_roll_slow,
    input  logic             pin_ck_div2,
    input  logic             pin_lr_pol,
    output logic [ATT_W-1:0] att_left,
    output logic [ATT_W-1:0] att_right,
    output logic             mute_on,
    output logic             dem_on,
    output logic [1:0]       dem_rate,
    output logic [1:0]       in_fmt,
    output logic [1:0]       out_len,
    output logic             roll_slow,
    output logic             ck_div2,
    output logic             lr_pol
);
    localparam int LATCH_I = 2;
    localparam int CLK_I   = 1;
    localparam int DATA_I  = 0;

    logic [2:0]        lvl, rise;
    logic [WORD_W-1:0] word;
    logic              word_ok;
    fmt_cfg_t          fmt;
    sys_cfg_t          sys;
    logic [ATT_W-1:0]  lvl_l, lvl_r;

    serial_cfg_sync #(.LINES(3), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ctl_latch, ctl_clk, ctl_data}),
        .level    (lvl),
        .rise     (rise)
    );

    serial_cfg_shift #(.W(WORD_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .bit_rise   (rise[CLK_I]),
        .bit_val    (lvl[DATA_I]),
        .latch_rise (rise[LATCH_I]),
        .word       (word),
        .word_ok    (word_ok)
    );

    serial_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .word      (word),
        .word_ok   (word_ok),
        .fmt       (fmt),
        .sys       (sys),
        .lvl_left  (lvl_l),
        .lvl_right (lvl_r)
    );

    always_comb begin
        if (sw_mode) begin
            att_left  = lvl_l;
            att_right = sys.common_att ? lvl_l : lvl_r;
            mute_on   = ~fmt.mute_off;
            dem_on    = fmt.dem_on;
            dem_rate  = sys.dem_rate;
            in_fmt    = fmt.in_fmt;
            out_len   = fmt.out_len;
            roll_slow = sys.roll_slow;
            ck_div2   = sys.ck_div2;
            lr_pol    = sys.lr_pol;
        end else begin
            att_left  = '1;
            att_right = '1;
            mute_on   = ~pin_mute_n;
            dem_on    = pin_dem_on;
            dem_rate  = pin_dem_rate;
            in_fmt    = pin_in_fmt;
            out_len   = pin_out_len;
            roll_slow = pin_roll_slow;
            ck_div2   = pin_ck_div2;
            lr_pol    = pin_lr_pol;
        end
    end

    a_r5_common_right_follows_left: assert property (@(posedge clk) disable iff (rst)
        (sw_mode && sys.common_att) |-> att_right == att_left);
endmodule

// File: tb/serial_cfg_top_test.sv
module serial_cfg_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_mode = 1'b1;
    logic ctl_latch = 1'b0, ctl_clk = 1'b0, ctl_data = 1'b0;
    logic [1:0] pin_in_fmt = 2'b00, pin_out_len = 2'b00, pin_dem_rate = 2'b00;
    logic pin_dem_on = 1'b0, pin_mute_n = 1'b1, pin_roll_slow = 1'b0;
    logic pin_ck_div2 = 1'b0, pin_lr_pol = 1'b0;
    logic [7:0] att_left, att_right;
    logic mute_on, dem_on, roll_slow, ck_div2, lr_pol;
    logic [1:0] dem_rate, in_fmt, out_len;

    always #4 clk = ~clk;

    serial_cfg_top uut (.*);

    // behavioural model state
    int m_l = 255, m_r = 255, m_ow = 0, m_iw = 0, m_dem = 0, m_muteoff = 1;
    int m_sf = 0, m_ck = 0, m_ro = 0, m_com = 0, m_lrp = 0;
    bit busy = 1'b1;
    int errors = 0, checks = 0;
    int cyc = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    task automatic model_apply(input logic [15:0] w);
        case (w[10:9])
            2'd0: if (w[8]) m_l = int'(w[7:0]);
            2'd1: if (w[8]) m_r = int'(w[7:0]);
            2'd2: begin
                m_ow = int'(w[5:4]); m_iw = int'(w[3:2]);
                m_dem = int'(w[1]); m_muteoff = int'(w[0]);
            end
            default: begin
                m_sf = int'(w[6:5]); m_ck = int'(w[4]); m_ro = int'(w[2]);
                m_com = int'(w[1]); m_lrp = int'(w[0]);
            end
        endcase
    endtask

    task automatic compare_all();
        if (sw_mode) begin
            chk("R3 att_left", att_left, m_l);
            chk("R5 att_right", att_right, m_com ? m_l : m_r);
            chk("R6 mute_on", mute_on, !m_muteoff);
            chk("R6 dem_on", dem_on, m_dem);
            chk("R6 in_fmt", in_fmt, m_iw);
            chk("R6 out_len", out_len, m_ow);
            chk("R7 dem_rate", dem_rate, m_sf);
            chk("R7 roll_slow", roll_slow, m_ro);
            chk("R7 ck_div2", ck_div2, m_ck);
            chk("R7 lr_pol", lr_pol, m_lrp);
        end else begin
            chk("R9 att_left", att_left, 255);
            chk("R9 att_right", att_right, 255);
            chk("R9 mute_on", mute_on, !pin_mute_n);
            chk("R9 dem_on", dem_on, pin_dem_on);
            chk("R9 in_fmt", in_fmt, pin_in_fmt);
            chk("R9 out_len", out_len, pin_out_len);
            chk("R9 dem_rate", dem_rate, pin_dem_rate);
            chk("R9 roll_slow", roll_slow, pin_roll_slow);
            chk("R9 ck_div2", ck_div2, pin_ck_div2);
            chk("R9 lr_pol", lr_pol, pin_lr_pol);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (!busy) compare_all();
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // nbits other than 16 sends a malformed word (R2)
    task automatic send(input logic [15:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            ctl_data = (i < 16) ? w[i] : 1'b0;
            wait_clk(4);
            ctl_clk = 1'b1;
            wait_clk(4);
            ctl_clk = 1'b0;
        end
        wait_clk(4);
        busy = 1'b1;
        ctl_latch = 1'b1;
        if (nbits == 16) model_apply(w);
        wait_clk(8);
        busy = 1'b0;
        ctl_latch = 1'b0;
        wait_clk(4);
    endtask

    function automatic logic [15:0] mk(input int sel, input int payload);
        return 16'((sel << 9) | payload);
    endfunction

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(1);
        @(negedge clk);
        // R8 reset state
        chk("R8 att_left", att_left, 8'hFF);
        chk("R8 att_right", att_right, 8'hFF);
        chk("R8 mute_on", mute_on, 0);
        chk("R8 dem_on", dem_on, 0);
        chk("R8 fmt/len/rate", {in_fmt, out_len, dem_rate}, 0);
        chk("R8 pol/roll/ck", {lr_pol, roll_slow, ck_div2}, 0);
        busy = 1'b0;
        wait_clk(2);

        // R6 register 2 patterns; reserved bits 15:11 set (R1)
        send(16'hF800 | mk(2, 6'b11_10_1_0), 16);
        @(negedge clk); chk("R6 mute active when bit0=0", mute_on, 1);
        chk("R1 reserved bits ignored, out_len", out_len, 3);
        send(mk(2, 6'b01_01_0_1), 16);
        send(mk(2, 6'b10_11_1_1), 16);

        // R7 register 3 patterns
        send(mk(3, 7'b11_1_0_1_0_1), 16);
        @(negedge clk); chk("R7 dem_rate 32k code", dem_rate, 3);
        send(mk(3, 7'b10_0_0_0_0_0), 16);

        // R3 load with code 80h, R4 no-load write
        send(mk(0, 9'h180), 16);
        @(negedge clk); chk("R3 left loaded", att_left, 8'h80);
        send(mk(0, 9'h010), 16);
        @(negedge clk); chk("R4 left unchanged", att_left, 8'h80);
        send(mk(1, 9'h140), 16);
        @(negedge clk); chk("R3 right loaded", att_right, 8'h40);
        send(mk(1, 9'h022), 16);
        @(negedge clk); chk("R4 right unchanged", att_right, 8'h40);

        // R5 common data on/off
        send(mk(3, 7'b00_0_0_0_1_0), 16);
        @(negedge clk); chk("R5 right follows left", att_right, 8'h80);
        send(mk(0, 9'h100), 16);
        @(negedge clk); chk("R5 full mute code shared", att_right, 8'h00);
        send(mk(3, 7'b00_0_0_0_0_0), 16);
        @(negedge clk); chk("R5 right independent again", att_right, 8'h40);

        // R2 malformed words aimed at register 2
        send(mk(2, 6'b00_00_1_0), 15);
        @(negedge clk); chk("R2 short word dropped", mute_on, 0);
        send(mk(2, 6'b00_00_1_0), 17);
        @(negedge clk); chk("R2 long word dropped", dem_on, 1);
        send(mk(2, 6'b00_01_0_1), 16);
        @(negedge clk); chk("R1 next full word accepted", in_fmt, 1);

        // R9 pin mode
        sw_mode = 1'b0;
        pin_mute_n = 1'b0; pin_in_fmt = 2'd3; pin_out_len = 2'd2;
        pin_dem_on = 1'b1; pin_dem_rate = 2'd2; pin_roll_slow = 1'b1;
        pin_ck_div2 = 1'b1; pin_lr_pol = 1'b1;
        wait_clk(2);
        @(negedge clk); chk("R9 pin mute active low", mute_on, 1);
        chk("R9 attenuation fixed", att_left, 8'hFF);
        send(mk(1, 9'h133), 16);
        pin_mute_n = 1'b1; pin_in_fmt = 2'd0;
        wait_clk(3);
        sw_mode = 1'b1;
        wait_clk(1);
        @(negedge clk); chk("R9 stored write applied on return", att_right, 8'h33);
        wait_clk(10);
        busy = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clk(100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule